// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Watermark Flags

This block is an 18-bit wide first-in first-out buffer that sits between two unrelated clock domains. A producer pushes words on the write clock and a consumer pops them on the read clock. Both enables are active low. Each side sees its own status: the read side gets empty and almost-empty, and the write side gets full, almost-full and half-full. All flags are active low.

Two watermark registers set where the almost flags trip. A shared load pin turns the data ports into a register access path. Writes with the pin low fill the low watermark first and the high watermark second, then wrap. Reads with the pin low return the two registers in that same order. A rewind input moves the read pointer back to physical location zero, so that data still held in storage can be replayed.

Each domain passes its pointer to the other as a Gray code through a two-flop synchroniser. Each flag is then derived from the local pointer and the synchronised remote pointer. The depth is a power-of-two parameter.

Top module: `flagged_fifo`

## Requirements
- R1: On a rising write-clock edge with wen_n low, ld_n high and ff_n high, din is stored. While ff_n is low a write attempt is dropped and stored data is unaffected.
- R2: On a rising read-clock edge with ren_n low, ld_n high and ef_n high, the oldest word is registered onto dout at that edge. A read attempt while ef_n is low leaves dout unchanged.
- R3: Words leave in the order they were written, and the write and read pointers only ever advance by one.
- R4: After the first write into an empty buffer, ef_n stays low until at least the second rising read-clock edge after the write edge. Once the write has crossed, ef_n goes high.
- R5: ff_n is low exactly when the stored count equals DEPTH.
- R6: hf_n is low when the stored count is DEPTH/2+1 or more.
- R7: pae_n is low when the stored count is less than or equal to the low watermark. paf_n is low when the count plus the high watermark is DEPTH or more.
- R8: With ld_n low and wen_n low, each write-clock edge stores the full 18-bit din into the next watermark register, low watermark first and high watermark second, and then the order repeats. Such a write stores no data word.
- R9: With ld_n low and ren_n low, each read-clock edge places the next watermark register on dout, low first and high second. This sequence is independent of the write-side sequence.
- R10: Reset (rst high, synchronous) clears both pointers, drives ef_n low, ff_n high and hf_n high, clears dout, sets both watermarks to 127, and restarts both register sequences at the low watermark.
- R11: A one-cycle rewind pulse on the read clock, given with ren_n and wen_n high, sets the read pointer to location 0. The following reads replay the stored words from the first one written. This is valid while no more than DEPTH words have been written since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, held across edges of both clocks |
| wen_n | input | 1 | Write enable, active low |
| ren_n | input | 1 | Read enable, active low |
| ld_n | input | 1 | Low selects watermark register access instead of data |
| rewind | input | 1 | Read-domain pulse that returns the read pointer to location 0 |
| din | input | 18 | Write data or watermark value |
| dout | output | 18 | Registered read data or watermark value |
| ef_n | output | 1 | Empty, active low, read domain |
| ff_n | output | 1 | Full, active low, write domain |
| hf_n | output | 1 | More than half full, active low, write domain |
| pae_n | output | 1 | Almost empty, active low, read domain |
| paf_n | output | 1 | Almost full, active low, write domain |

## Verification
A pop or a watermark readback lands on dout at the same read-clock edge that takes it. The bench therefore drives enables at a falling edge and samples dout at the next falling edge. ff_n, hf_n and paf_n react to local writes at the write edge, but the other domain's pointer reaches them only after two synchroniser edges. The same holds for ef_n and pae_n on the read side. For this reason every flag check waits four edges of each clock after the last stimulus. The one exception is the R4 check, which samples ef_n two nanoseconds after the write edge, when at most one read edge can have passed, and expects it still low.

// File: rtl/fifo_pf_pkg.sv
package fifo_pf_pkg;

    localparam int FIFO_DATA_W     = 18;
    localparam int FIFO_ADDR_W     = 4;
    localparam int FIFO_DEF_OFFSET = 127;

    // Which watermark register the next access touches
    typedef enum logic {
        OFS_LOW  = 1'b0,
        OFS_HIGH = 1'b1
    } ofs_sel_e;

    // Write-domain status, all active low
    typedef struct packed {
        logic full_n;
        logic half_n;
        logic afull_n;
    } wflags_t;

    function automatic ofs_sel_e next_sel(input ofs_sel_e s);
        return (s == OFS_LOW) ? OFS_HIGH : OFS_LOW;
    endfunction

endpackage

// File: rtl/gray_decode.sv
module gray_decode #(
    parameter int W = 5
) (
    input  logic [W-1:0] g,
    output logic [W-1:0] b
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign b[i] = ^g[W-1:i];
    end
endmodule

// File: rtl/ptr_sync.sv
module ptr_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/fifo_mem.sv
module fifo_mem #(
    parameter int DW = 18,
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/fifo_wr_side.sv
module fifo_wr_side
    import fifo_pf_pkg::*;
#(
    parameter int DW      = 18,
    parameter int AW      = 4,
    parameter int DEF_OFS = 127
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wen_n,
    input  logic          ld_n,
    input  logic [DW-1:0] din,
    input  logic [AW:0]   rgray_s,
    output logic [AW:0]   wbin,
    output logic [AW:0]   wgray,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [DW-1:0] low_ofs,
    output logic [DW-1:0] high_ofs,
    output wflags_t       flags
);
    localparam int PW    = AW + 1;
    localparam int CW    = DW + 2;
    localparam int DEPTH = 1 << AW;

    logic [PW-1:0] rbin_s;
    logic [PW-1:0] cnt;
    logic [PW-1:0] wbin_nxt;
    logic          full;
    logic          do_load;
    logic          do_push;
    ofs_sel_e      sel;

    gray_decode #(.W(PW)) u_dec (.g(rgray_s), .b(rbin_s));

    assign cnt      = wbin - rbin_s;
    assign full     = (cnt == PW'(DEPTH));
    assign do_load  = !ld_n && !wen_n;
    assign do_push  = ld_n && !wen_n && !full;
    assign wbin_nxt = wbin + PW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin     <= '0;
            wgray    <= '0;
            sel      <= OFS_LOW;
            low_ofs  <= DW'(DEF_OFS);
            high_ofs <= DW'(DEF_OFS);
        end else begin
            if (do_push) begin
                wbin  <= wbin_nxt;
                wgray <= wbin_nxt ^ (wbin_nxt >> 1);
            end
            if (do_load) begin
                if (sel == OFS_LOW) low_ofs  <= din;
                else                high_ofs <= din;
                sel <= next_sel(sel);
            end
        end
    end

    assign mem_we    = do_push;
    assign mem_waddr = wbin[AW-1:0];

    always_comb begin
        flags.full_n  = !full;
        flags.half_n  = !(cnt >= PW'(DEPTH / 2 + 1));
        flags.afull_n = !((CW'(cnt) + CW'(high_ofs)) >= CW'(DEPTH));
    end
endmodule

// File: rtl/fifo_rd_side.sv
module fifo_rd_side
    import fifo_pf_pkg::*;
#(
    parameter int DW = 18,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ren_n,
    input  logic          ld_n,
    input  logic          rewind,
    input  logic [AW:0]   wgray_s,
    input  logic [DW-1:0] low_ofs,
    input  logic [DW-1:0] high_ofs,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW:0]   rbin,
    output logic [AW:0]   rgray,
    output logic [AW-1:0] mem_raddr,
    output logic [DW-1:0] dout,
    output logic          ef_n,
    output logic          pae_n
);
    localparam int PW = AW + 1;
    localparam int CW = DW + 2;

    logic [PW-1:0] wbin_s;
    logic [PW-1:0] cnt;
    logic [PW-1:0] rbin_nxt;
    logic          empty;
    ofs_sel_e      sel;

    gray_decode #(.W(PW)) u_dec (.g(wgray_s), .b(wbin_s));

    assign cnt      = wbin_s - rbin;
    assign empty    = (rgray == wgray_s);
    assign rbin_nxt = rbin + PW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin  <= '0;
            rgray <= '0;
            sel   <= OFS_LOW;
            dout  <= '0;
        end else if (rewind) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (!ld_n && !ren_n) begin
            dout <= (sel == OFS_LOW) ? low_ofs : high_ofs;
            sel  <= next_sel(sel);
        end else if (!ren_n && !empty) begin
            dout  <= mem_rdata;
            rbin  <= rbin_nxt;
            rgray <= rbin_nxt ^ (rbin_nxt >> 1);
        end
    end

    assign mem_raddr = rbin[AW-1:0];
    assign ef_n      = !empty;
    assign pae_n     = !(CW'(cnt) <= CW'(low_ofs));
endmodule

// File: rtl/flagged_fifo.sv
module flagged_fifo
    import fifo_pf_pkg::*;
#(
    parameter int DATA_W  = FIFO_DATA_W,
    parameter int ADDR_W  = FIFO_ADDR_W,
    parameter int DEF_OFS = FIFO_DEF_OFFSET
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst,
    input  logic              wen_n,
    input  logic              ren_n,
    input  logic              ld_n,
    input  logic              rewind,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              ef_n,
    output logic              ff_n,
    output logic              hf_n,
    output logic              pae_n,
    output logic              paf_n
);
    localparam int PW = ADDR_W + 1;

    logic [PW-1:0]     wbin, wgray, rbin, rgray;
    logic [PW-1:0]     wgray_s, rgray_s;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr, mem_raddr;
    logic [DATA_W-1:0] mem_rdata;
    logic [DATA_W-1:0] low_ofs, high_ofs;
    wflags_t           wflags;

    fifo_wr_side #(.DW(DATA_W), .AW(ADDR_W), .DEF_OFS(DEF_OFS)) u_wr (
        .clk(wclk), .rst(rst), .wen_n(wen_n), .ld_n(ld_n), .din(din),
        .rgray_s(rgray_s), .wbin(wbin), .wgray(wgray),
        .mem_we(mem_we), .mem_waddr(mem_waddr),
        .low_ofs(low_ofs), .high_ofs(high_ofs), .flags(wflags)
    );

    fifo_rd_side #(.DW(DATA_W), .AW(ADDR_W)) u_rd (
        .clk(rclk), .rst(rst), .ren_n(ren_n), .ld_n(ld_n), .rewind(rewind),
        .wgray_s(wgray_s), .low_ofs(low_ofs), .high_ofs(high_ofs),
        .mem_rdata(mem_rdata), .rbin(rbin), .rgray(rgray),
        .mem_raddr(mem_raddr), .dout(dout), .ef_n(ef_n), .pae_n(pae_n)
    );

    ptr_sync #(.W(PW)) u_w2r (.clk(rclk), .rst(rst), .d(wgray), .q(wgray_s));
    ptr_sync #(.W(PW)) u_r2w (.clk(wclk), .rst(rst), .d(rgray), .q(rgray_s));

    fifo_mem #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
        .wclk(wclk), .we(mem_we), .waddr(mem_waddr), .wdata(din),
        .raddr(mem_raddr), .rdata(mem_rdata)
    );

    assign ff_n  = wflags.full_n;
    assign hf_n  = wflags.half_n;
    assign paf_n = wflags.afull_n;
endmodule

// File: rtl/fifo_pf_checker.sv
module fifo_pf_checker #(
    parameter int PW = 5
) (
    input logic          wclk,
    input logic          rclk,
    input logic          rst,
    input logic          rewind,
    input logic          ef_n,
    input logic          ff_n,
    input logic          hf_n,
    input logic          pae_n,
    input logic          paf_n,
    input logic [PW-1:0] wbin,
    input logic [PW-1:0] rbin
);
    // R1
    no_overflow_chk: assert property (@(posedge wclk) disable iff (rst)
        !ff_n |=> $stable(wbin));

    // R2
    no_underflow_chk: assert property (@(posedge rclk) disable iff (rst)
        (!ef_n && !rewind) |=> $stable(rbin));

    // R5 R6 R7
    full_flags_chk: assert property (@(posedge wclk) disable iff (rst)
        !ff_n |-> (!hf_n && !paf_n));

    // R7
    empty_ae_chk: assert property (@(posedge rclk) disable iff (rst)
        !ef_n |-> !pae_n);

    // R3
    wr_step_chk: assert property (@(posedge wclk) disable iff (rst)
        (wbin != $past(wbin)) |-> (wbin == $past(wbin) + PW'(1)));

    // R11
    rd_step_chk: assert property (@(posedge rclk) disable iff (rst)
        (rbin != $past(rbin)) |-> ((rbin == $past(rbin) + PW'(1)) || (rbin == '0)));
endmodule

bind flagged_fifo fifo_pf_checker #(.PW(PW)) u_chk (
    .wclk(wclk), .rclk(rclk), .rst(rst), .rewind(rewind),
    .ef_n(ef_n), .ff_n(ff_n), .hf_n(hf_n), .pae_n(pae_n), .paf_n(paf_n),
    .wbin(wbin), .rbin(rbin)
);

// File: tb/flagged_fifo_bench.sv
`timescale 1ns/1ps
module flagged_fifo_bench;
    localparam int DW    = 18;
    localparam int DEPTH = 16;

    logic          wclk = 1'b0, rclk = 1'b0, rst = 1'b1;
    logic          wen_n = 1'b1, ren_n = 1'b1, ld_n = 1'b1, rewind = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          ef_n, ff_n, hf_n, pae_n, paf_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 wclk = ~wclk;
    always #3 rclk = ~rclk;

    flagged_fifo #(.DATA_W(DW), .ADDR_W(4), .DEF_OFS(127)) u_flagged_fifo (
        .wclk(wclk), .rclk(rclk), .rst(rst), .wen_n(wen_n), .ren_n(ren_n),
        .ld_n(ld_n), .rewind(rewind), .din(din), .dout(dout),
        .ef_n(ef_n), .ff_n(ff_n), .hf_n(hf_n), .pae_n(pae_n), .paf_n(paf_n)
    );

    localparam logic [DW-1:0] PAT [DEPTH] = '{
        18'h00001, 18'h3FFFE, 18'h15555, 18'h2AAAA,
        18'h00F0F, 18'h3C3C3, 18'h12345, 18'h0ABCD,
        18'h20000, 18'h00000, 18'h1FFFF, 18'h33333,
        18'h0C0C0, 18'h24924, 18'h1B6DB, 18'h3F00F
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // {ef_n, ff_n, hf_n, pae_n, paf_n} for a given count and watermarks
    function automatic logic [4:0] exp_flags(input int k, input int lo, input int hi);
        return {k != 0, k != DEPTH, !(k >= DEPTH / 2 + 1), !(k <= lo), !(k + hi >= DEPTH)};
    endfunction

    task automatic settle();
        repeat (4) @(negedge wclk);
        repeat (4) @(negedge rclk);
    endtask

    task automatic wr_word(input logic [DW-1:0] d, input logic load);
        @(negedge wclk);
        din = d; wen_n = 1'b0; ld_n = !load;
        @(negedge wclk);
        wen_n = 1'b1; ld_n = 1'b1;
    endtask

    task automatic rd_word(input logic load);
        @(negedge rclk);
        ren_n = 1'b0; ld_n = !load;
        @(negedge rclk);
        ren_n = 1'b1; ld_n = 1'b1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (4) @(negedge rclk);
        rst = 1'b0;
        settle();
    endtask

    initial begin
        repeat (100000) @(posedge wclk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R10 reset state; R7 with both watermarks at 127
        chk("R10 flags", 32'({ef_n, ff_n, hf_n, pae_n, paf_n}), 32'(exp_flags(0, 127, 127)));
        chk("R10 dout", 32'(dout), 32'h0);
        rd_word(1'b1);
        chk("R10/R9 low watermark default", 32'(dout), 32'd127);
        rd_word(1'b1);
        chk("R10/R9 high watermark default", 32'(dout), 32'd127);

        // R8 load low then high
        wr_word(18'd3, 1'b1);
        wr_word(18'd4, 1'b1);
        settle();
        chk("R8 load stores no data", 32'(ef_n), 32'd0);
        rd_word(1'b1);
        chk("R9 readback low", 32'(dout), 32'd3);
        rd_word(1'b1);
        chk("R9 readback high", 32'(dout), 32'd4);
        rd_word(1'b0);
        chk("R2 read while empty keeps dout", 32'(dout), 32'd4);

        // Vector table: fill to full, flags after each write
        for (int i = 0; i < DEPTH; i++) begin
            wr_word(PAT[i], 1'b0);
            if (i == 0) chk("R4 ef_n still low right after write", 32'(ef_n), 32'd0);
            settle();
            chk("R4-R7 flags after write", 32'({ef_n, ff_n, hf_n, pae_n, paf_n}),
                32'(exp_flags(i + 1, 3, 4)));
        end

        wr_word(18'h3FFFF, 1'b0);
        settle();
        chk("R1 full stays full", 32'(ff_n), 32'd0);

        for (int i = 0; i < DEPTH; i++) begin
            rd_word(1'b0);
            chk("R3 order", 32'(dout), 32'(PAT[i]));
        end
        settle();
        chk("R1/R5 drained flags", 32'({ef_n, ff_n, hf_n, pae_n, paf_n}),
            32'(exp_flags(0, 3, 4)));
        rd_word(1'b0);
        chk("R2 underflow keeps dout", 32'(dout), 32'(PAT[DEPTH-1]));

        // R11 rewind
        @(negedge rclk); rewind = 1'b1;
        @(negedge rclk); rewind = 1'b0;
        settle();
        chk("R11 data visible after rewind", 32'(ef_n), 32'd1);
        rd_word(1'b0);
        chk("R11 replay first", 32'(dout), 32'(PAT[0]));
        rd_word(1'b0);
        chk("R11 replay second", 32'(dout), 32'(PAT[1]));

        // R10 second reset restores watermarks and sequence
        do_reset();
        chk("R10 flags after reset", 32'({ef_n, ff_n, hf_n, pae_n, paf_n}),
            32'(exp_flags(0, 127, 127)));
        rd_word(1'b1);
        chk("R10 watermark restored", 32'(dout), 32'd127);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule